// File: doc/BRIEF.md
# Stage Boundary Register with Hold and Nop Insertion

This block is the register that separates two adjacent stages of a five-stage in-order processor pipeline. On every rising clock edge it captures one instruction's bundle of fields: a status code, an operation code, a function code, a set of data values, two destination register IDs and two source register IDs. The register always holds exactly one instruction, so these fields have no valid/ready handshake. Instead, two plain control pins from the pipeline controller pick the update for the coming edge. With neither pin high, the register loads the upstream bundle. With the hold pin high, it keeps what it has. With the nop pin high, it loads a fixed nop pattern.

The nop pattern marks every register ID as "no register" (all ones). Because of this, hazard and forwarding logic further down never matches against an inserted nop, and the nop writes nothing as it travels through the later stages. A synchronous reset loads the same nop pattern. The controller must never raise hold and nop together. If it does, the block reports it on an error pin in the same cycle and keeps its contents. The block does not decide when to hold or insert nops. It only obeys the two pins.

Top module: `stage_latch`

## Requirements
- R1: The outputs change only at a rising clock edge. A change on any data or control input between edges leaves the outputs unchanged until the next edge.
- R2: When `stall_i`=0 and `bubble_i`=0 at an edge (and `rst`=0), every output field takes the value of the matching input field.
- R3: When `stall_i`=1 and `bubble_i`=0 at an edge, every output field keeps its previous value, whatever the inputs carry.
- R4: When `stall_i`=0 and `bubble_i`=1 at an edge, the outputs load the nop pattern, whatever the inputs carry. In that pattern `q_stat`=0 (status codes: 0 bubble, 1 normal, 2 halt, 3 fault), `q_op`=`NOP_OP` (default 1), `q_fn`=0 and every data value is 0.
- R5: In the nop pattern, both destination IDs and both source IDs are all ones (0xF at the default width), the code for "no register".
- R6: When `rst`=1 at an edge, the outputs load the nop pattern of R4/R5. This takes priority over both control pins. A reset raised between edges has no effect before the next edge.
- R7: `ctl_err` is high in exactly those cycles in which `stall_i` and `bubble_i` are both high. It is combinational, with no clock delay.
- R8: When `stall_i` and `bubble_i` are both high at an edge (and `rst`=0), the outputs keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads the nop pattern |
| stall_i | input | 1 | Hold the current contents at the next edge |
| bubble_i | input | 1 | Load the nop pattern at the next edge |
| d_stat | input | ST_W | Incoming status code |
| d_op | input | OP_W | Incoming operation code |
| d_fn | input | FN_W | Incoming function code |
| d_vals | input | NVAL*DATA_W | Incoming data values, slot k at bits [k*DATA_W +: DATA_W] |
| d_dst_e | input | ID_W | Incoming result destination register ID |
| d_dst_m | input | ID_W | Incoming load destination register ID |
| d_src_a | input | ID_W | Incoming first source register ID |
| d_src_b | input | ID_W | Incoming second source register ID |
| q_stat | output | ST_W | Registered status code |
| q_op | output | OP_W | Registered operation code |
| q_fn | output | FN_W | Registered function code |
| q_vals | output | NVAL*DATA_W | Registered data values |
| q_dst_e | output | ID_W | Registered result destination ID |
| q_dst_m | output | ID_W | Registered load destination ID |
| q_src_a | output | ID_W | Registered first source ID |
| q_src_b | output | ID_W | Registered second source ID |
| ctl_err | output | 1 | High while hold and nop are requested together |

## Verification
The assertions assume that `rst` is driven cleanly relative to the clock. They also assume that the control pins settle before each edge. Beyond that they accept any control pattern, including the illegal one, which they check for the hold behaviour and the error flag. The stimulus changes every input half a cycle away from the active edge. It draws random bundles together with random combinations of hold, nop and reset, so that the illegal pair and reset overlapping either pin come up regularly. Directed steps then place changes between edges to probe R1 and the non-asynchronous reset.

// File: rtl/plr_pkg.sv
package plr_pkg;

  // Update action chosen for the coming clock edge
  typedef enum logic [1:0] {
    UPD_LOAD = 2'd0,
    UPD_HOLD = 2'd1,
    UPD_NOP  = 2'd2
  } upd_e;

  // Status codes carried with each instruction
  localparam logic [1:0] STAT_BUB  = 2'd0;
  localparam logic [1:0] STAT_OK   = 2'd1;
  localparam logic [1:0] STAT_HLT  = 2'd2;
  localparam logic [1:0] STAT_FLT  = 2'd3;

endpackage

// File: rtl/plr_mode_dec.sv
module plr_mode_dec
  import plr_pkg::*;
(
  input  logic stall_i,
  input  logic bubble_i,
  output upd_e mode_o,
  output logic err_o
);

  // Holding wins when both are requested, so no state is lost
  always_comb begin
    if (stall_i)       mode_o = UPD_HOLD;
    else if (bubble_i) mode_o = UPD_NOP;
    else               mode_o = UPD_LOAD;
  end

  assign err_o = stall_i & bubble_i;

endmodule

// File: rtl/plr_slot.sv
module plr_slot
  import plr_pkg::*;
#(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    NOP_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  upd_e         mode_i,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= NOP_VAL;
    end else begin
      case (mode_i)
        UPD_LOAD: q <= d;
        UPD_NOP:  q <= NOP_VAL;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/stage_latch.sv
module stage_latch
  import plr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NVAL   = 3,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned FN_W   = 4,
  parameter int unsigned ST_W   = 2,
  parameter int unsigned NOP_OP = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stall_i,
  input  logic                   bubble_i,
  input  logic [ST_W-1:0]        d_stat,
  input  logic [OP_W-1:0]        d_op,
  input  logic [FN_W-1:0]        d_fn,
  input  logic [NVAL*DATA_W-1:0] d_vals,
  input  logic [ID_W-1:0]        d_dst_e,
  input  logic [ID_W-1:0]        d_dst_m,
  input  logic [ID_W-1:0]        d_src_a,
  input  logic [ID_W-1:0]        d_src_b,
  output logic [ST_W-1:0]        q_stat,
  output logic [OP_W-1:0]        q_op,
  output logic [FN_W-1:0]        q_fn,
  output logic [NVAL*DATA_W-1:0] q_vals,
  output logic [ID_W-1:0]        q_dst_e,
  output logic [ID_W-1:0]        q_dst_m,
  output logic [ID_W-1:0]        q_src_a,
  output logic [ID_W-1:0]        q_src_b,
  output logic                   ctl_err
);

  localparam logic [ID_W-1:0] NO_REG   = {ID_W{1'b1}};
  localparam logic [ST_W-1:0] NOP_STAT = ST_W'(STAT_BUB);
  localparam logic [OP_W-1:0] NOP_OPC  = OP_W'(NOP_OP);
  localparam int unsigned     NIDS     = 4;

  upd_e mode;

  plr_mode_dec u_dec (
    .stall_i (stall_i),
    .bubble_i(bubble_i),
    .mode_o  (mode),
    .err_o   (ctl_err)
  );

  plr_slot #(.W(ST_W), .NOP_VAL(NOP_STAT)) u_stat (
    .clk(clk), .rst(rst), .mode_i(mode), .d(d_stat), .q(q_stat)
  );

  plr_slot #(.W(OP_W), .NOP_VAL(NOP_OPC)) u_op (
    .clk(clk), .rst(rst), .mode_i(mode), .d(d_op), .q(q_op)
  );

  plr_slot #(.W(FN_W), .NOP_VAL('0)) u_fn (
    .clk(clk), .rst(rst), .mode_i(mode), .d(d_fn), .q(q_fn)
  );

  // One slot per data value
  for (genvar k = 0; k < NVAL; k++) begin : g_val
    plr_slot #(.W(DATA_W), .NOP_VAL('0)) u_val (
      .clk   (clk),
      .rst   (rst),
      .mode_i(mode),
      .d     (d_vals[k*DATA_W +: DATA_W]),
      .q     (q_vals[k*DATA_W +: DATA_W])
    );
  end

  // Register IDs all reset to "no register"
  logic [NIDS*ID_W-1:0] ids_d, ids_q;
  assign ids_d = {d_dst_e, d_dst_m, d_src_a, d_src_b};

  for (genvar j = 0; j < NIDS; j++) begin : g_id
    plr_slot #(.W(ID_W), .NOP_VAL(NO_REG)) u_id (
      .clk   (clk),
      .rst   (rst),
      .mode_i(mode),
      .d     (ids_d[j*ID_W +: ID_W]),
      .q     (ids_q[j*ID_W +: ID_W])
    );
  end

  assign {q_dst_e, q_dst_m, q_src_a, q_src_b} = ids_q;

endmodule

// File: rtl/plr_chk.sv
module plr_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NVAL   = 3,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned FN_W   = 4,
  parameter int unsigned ST_W   = 2,
  parameter int unsigned NOP_OP = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   stall_i,
  input logic                   bubble_i,
  input logic [ST_W-1:0]        d_stat,
  input logic [OP_W-1:0]        d_op,
  input logic [FN_W-1:0]        d_fn,
  input logic [NVAL*DATA_W-1:0] d_vals,
  input logic [ID_W-1:0]        d_dst_e,
  input logic [ID_W-1:0]        d_dst_m,
  input logic [ID_W-1:0]        d_src_a,
  input logic [ID_W-1:0]        d_src_b,
  input logic [ST_W-1:0]        q_stat,
  input logic [OP_W-1:0]        q_op,
  input logic [FN_W-1:0]        q_fn,
  input logic [NVAL*DATA_W-1:0] q_vals,
  input logic [ID_W-1:0]        q_dst_e,
  input logic [ID_W-1:0]        q_dst_m,
  input logic [ID_W-1:0]        q_src_a,
  input logic [ID_W-1:0]        q_src_b,
  input logic                   ctl_err
);

  localparam int unsigned BW = ST_W + OP_W + FN_W + NVAL*DATA_W + 4*ID_W;
  localparam logic [BW-1:0] NOP_B = {ST_W'(0), OP_W'(NOP_OP), FN_W'(0),
                                     {(NVAL*DATA_W){1'b0}}, {(4*ID_W){1'b1}}};

  logic [BW-1:0] din, dout;
  assign din  = {d_stat, d_op, d_fn, d_vals, d_dst_e, d_dst_m, d_src_a, d_src_b};
  assign dout = {q_stat, q_op, q_fn, q_vals, q_dst_e, q_dst_m, q_src_a, q_src_b};

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !bubble_i) |=> dout == $past(din));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !bubble_i) |=> $stable(dout));

  // R4
  nop_chk: assert property (@(posedge clk) disable iff (rst)
    (bubble_i && !stall_i) |=> dout == NOP_B);

  // R5
  noreg_chk: assert property (@(posedge clk) disable iff (rst)
    (bubble_i && !stall_i) |=> (&q_dst_e && &q_dst_m && &q_src_a && &q_src_b));

  // R6
  reset_chk: assert property (@(posedge clk)
    rst |=> dout == NOP_B);

  // R7
  err_chk: assert property (@(posedge clk)
    ctl_err == (stall_i && bubble_i));

  // R8
  both_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && bubble_i) |=> $stable(dout));

endmodule

bind stage_latch plr_chk #(
  .DATA_W(DATA_W), .NVAL(NVAL), .ID_W(ID_W), .OP_W(OP_W),
  .FN_W(FN_W), .ST_W(ST_W), .NOP_OP(NOP_OP)
) u_chk (.*);

// File: tb/sim_stage_latch.sv
`timescale 1ns/1ps
module sim_stage_latch;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned NVAL   = 3;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned BW     = 2 + 4 + 4 + NVAL*DATA_W + 4*ID_W;
  // Nop pattern from R4/R5: stat 0, op 1, fn 0, values 0, IDs 0xF
  localparam logic [BW-1:0] NOPB = {2'd0, 4'd1, 4'd0,
                                    {(NVAL*DATA_W){1'b0}}, 16'hFFFF};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, stall_i, bubble_i;
  logic [BW-1:0] din, act, expv;
  logic [1:0] d_stat, q_stat;
  logic [3:0] d_op, d_fn, q_op, q_fn;
  logic [NVAL*DATA_W-1:0] d_vals, q_vals;
  logic [ID_W-1:0] d_dst_e, d_dst_m, d_src_a, d_src_b;
  logic [ID_W-1:0] q_dst_e, q_dst_m, q_src_a, q_src_b;
  logic ctl_err;

  assign {d_stat, d_op, d_fn, d_vals, d_dst_e, d_dst_m, d_src_a, d_src_b} = din;
  assign act = {q_stat, q_op, q_fn, q_vals, q_dst_e, q_dst_m, q_src_a, q_src_b};

  stage_latch u0 (
    .clk(clk), .rst(rst), .stall_i(stall_i), .bubble_i(bubble_i),
    .d_stat(d_stat), .d_op(d_op), .d_fn(d_fn), .d_vals(d_vals),
    .d_dst_e(d_dst_e), .d_dst_m(d_dst_m), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .q_stat(q_stat), .q_op(q_op), .q_fn(q_fn), .q_vals(q_vals),
    .q_dst_e(q_dst_e), .q_dst_m(q_dst_m), .q_src_a(q_src_a), .q_src_b(q_src_b),
    .ctl_err(ctl_err)
  );

  int checks = 0;
  int fails  = 0;
  string last_tag;

  function automatic logic [BW-1:0] nxt(input logic [BW-1:0] cur, input logic [BW-1:0] nin,
                                        input logic st, input logic bu, input logic rs);
    if (rs) return NOPB;
    if (st) return cur;
    if (bu) return NOPB;
    return nin;
  endfunction

  function automatic logic [BW-1:0] rnd_bundle();
    logic [BW-1:0] b;
    for (int i = 0; i < BW; i += 32) b[i +: 32] = $urandom;
    return b;
  endfunction

  task automatic chk_bus(input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic chk_bit(input string tag, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, a, e);
    end
  endtask

  // Called at a falling edge: check the outputs, drive new inputs, update the model
  task automatic cyc(input logic st, input logic bu, input logic rs,
                     input logic [BW-1:0] b, input string tag);
    chk_bus(last_tag);
    stall_i = st; bubble_i = bu; rst = rs; din = b;
    #1;
    chk_bit("R7 ctl_err", ctl_err, st & bu);
    chk_bus(rs ? "R1/R6 outputs before edge" : "R1 outputs before edge");
    expv = nxt(expv, b, st, bu, rs);
    last_tag = tag;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [BW-1:0] b;
    void'($urandom(32'd20240611));
    rst = 1'b1; stall_i = 1'b0; bubble_i = 1'b0; din = rnd_bundle();
    @(negedge clk); @(negedge clk);
    expv = NOPB;
    last_tag = "R6 reset state";
    // directed
    cyc(1'b0, 1'b0, 1'b0, rnd_bundle(), "R2 load A");
    cyc(1'b0, 1'b0, 1'b0, {2'd1, 4'd6, 4'd2, {(NVAL*DATA_W){1'b1}}, 16'h0123}, "R2 load B");
    cyc(1'b1, 1'b0, 1'b0, rnd_bundle(), "R3 hold ignores input");
    cyc(1'b1, 1'b0, 1'b0, rnd_bundle(), "R3 hold twice");
    cyc(1'b0, 1'b1, 1'b0, rnd_bundle(), "R4/R5 nop pattern");
    cyc(1'b0, 1'b0, 1'b0, {2'd2, 4'd3, 4'd1, {(NVAL*DATA_W){1'b0}}, 16'hABCD}, "R2 load after nop");
    cyc(1'b1, 1'b1, 1'b0, rnd_bundle(), "R8 both high hold");
    cyc(1'b1, 1'b0, 1'b1, rnd_bundle(), "R6 reset over hold");
    cyc(1'b0, 1'b0, 1'b0, rnd_bundle(), "R2 load after reset");
    cyc(1'b1, 1'b1, 1'b1, rnd_bundle(), "R6 reset over both");
    cyc(1'b0, 1'b0, 1'b0, rnd_bundle(), "R2 load");
    // random
    for (int n = 0; n < 600; n++) begin
      logic st, bu, rs;
      string t;
      st = ($urandom % 4) == 0;
      bu = ($urandom % 4) == 0;
      rs = ($urandom % 20) == 0;
      b  = rnd_bundle();
      if (rs)           t = "R6 random reset";
      else if (st & bu) t = "R8 random both";
      else if (st)      t = "R3 random hold";
      else if (bu)      t = "R4/R5 random nop";
      else              t = "R2 random load";
      cyc(st, bu, rs, b, t);
    end
    chk_bus(last_tag);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule